// File: doc/BRIEF.md
# Windowed Register Access Bridge

This bridge connects a simple 32-bit register master to a device register space whose slave port decodes only a limited address range. Requests whose offset lies below the aperture base go straight to the slave. Any larger offset is reached through a sliding window. The bridge first writes the window number into a window-select register on the slave. It then accesses the requested offset inside a fixed aperture region. Window selection can be switched off with a mode input, and then every offset is forwarded as given.

The bridge remembers which window it last programmed. The extra select write appears only when a request falls in a different window from the remembered one, so a run of accesses within one window costs a single slave transaction each. After a request is accepted, the master side stays busy until the whole slave sequence is finished. This keeps the select write and the data access together as one unbroken pair. Reads return the slave's data unchanged, with a one-cycle valid pulse.

Each master request is a single read or write with a valid/ready handshake. A request is accepted on a rising clock edge where `m_valid` and `m_ready` are both high. The first slave request appears in the following cycle.

Top module: `regwin_bridge`

## Requirements
- R1: With `window_on` high, a request whose offset is below 0x80000 produces exactly one slave transaction, at the same offset and with the same direction and write data, and no select write.
- R2: With `window_on` low, every request produces exactly one slave transaction at the unchanged offset, whatever the offset, and leaves the remembered window untouched.
- R3: With `window_on` high and offset at or above 0x80000, the data transaction targets slave offset 0x80000 + (offset & 0x7FFFF). The window number is offset bits [24:19], and bits above 24 are ignored.
- R4: A select write is a slave write to offset 0x310C with data 0x8000_0000 | window. Bit 31 is set, bits [5:0] hold the window number and all other bits are zero. It is issued only when the window differs from the remembered one.
- R5: After reset no window is remembered, so the first windowed request always issues a select write, even for window 0.
- R6: When a select write is needed, its slave handshake completes before the data transaction is presented. `m_ready` stays low from acceptance until the sequence completes, so no other master request can come between the two.
- R7: While `s_valid` is high and `s_ready` is low, `s_valid`, `s_addr`, `s_write` and `s_wdata` hold their values.
- R8: For a read, `m_rvalid` is high for exactly one cycle, in the cycle after `s_rvalid`. In that cycle `m_rdata` equals the sampled `s_rdata`, and `m_ready` returns high in the same cycle. A write completes with `m_ready` returning high in the cycle after the data handshake.
- R9: The remembered window changes only when a select write's handshake completes, and it then holds the number that was written.
- R10: During and after reset, `m_ready` is high and `s_valid` and `m_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| window_on | input | 1 | 1: windowing for offsets at or above the aperture base; 0: forward every offset |
| m_valid | input | 1 | Master request valid |
| m_ready | output | 1 | Bridge idle and able to accept a request |
| m_write | input | 1 | 1 = write, 0 = read |
| m_addr | input | 32 | Master register offset |
| m_wdata | input | 32 | Master write data |
| m_rvalid | output | 1 | One-cycle read data valid |
| m_rdata | output | 32 | Read data returned to the master |
| s_valid | output | 1 | Slave request valid |
| s_ready | input | 1 | Slave accepts the request |
| s_write | output | 1 | Slave request direction, 1 = write |
| s_addr | output | 32 | Slave register offset |
| s_wdata | output | 32 | Slave write data |
| s_rvalid | input | 1 | Slave read data valid |
| s_rdata | input | 32 | Slave read data |

## Verification
Directed requests cover the points where the routing could be wrong. One offset sits just below the aperture base and one sits exactly at it. One request lands in window 0 through a high address bit. One goes to the topmost window. Together these separate a wrong compare from a wrong mask or a wrong field slice. A bypassed request into a new window, followed by a windowed request in the old window, shows whether bypass traffic disturbs the remembered window. Random sequences mix the mode, the direction, low offsets and a small set of windows, so that repeated windows test the hit path and switches test the miss path. The slave model stalls `s_ready` and delays read data by random amounts, which exercises the ordering, hold and response timing rules.

// File: rtl/regwin_pkg.sv
// Shared types for the windowed register access bridge.
// Assumes: one outstanding master request at a time.
package regwin_pkg;

    // Sequencer states: idle, window-select write, data access, read wait
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEL   = 2'd1,
        ST_ACC   = 2'd2,
        ST_RWAIT = 2'd3
    } seq_state_t;

endpackage

// File: rtl/regwin_decode.sv
// Address decode for the bridge: decides whether an offset needs the
// window, extracts the window number and forms the aperture offset.
// Assumes: WIN_SHIFT + WIN_BITS <= ADDR_W. Purely combinational.
module regwin_decode #(
    parameter int ADDR_W    = 32,
    parameter int WIN_SHIFT = 19,
    parameter int WIN_BITS  = 6
) (
    input  logic                window_on,
    input  logic [ADDR_W-1:0]   addr,
    output logic                use_window,
    output logic [WIN_BITS-1:0] win_num,
    output logic [ADDR_W-1:0]   ap_addr
);
    localparam logic [ADDR_W-1:0] APERTURE = ADDR_W'(1) << WIN_SHIFT;
    localparam logic [ADDR_W-1:0] OFS_MASK = APERTURE - ADDR_W'(1);

    // Route choice, window field and aperture offset
    always_comb begin
        use_window = window_on && (addr >= APERTURE);
        win_num    = addr[WIN_SHIFT +: WIN_BITS];
        ap_addr    = APERTURE | (addr & OFS_MASK);
    end

endmodule

// File: rtl/regwin_cache.sv
// Remembers the window number last written to the slave's select register.
// Resets to "nothing remembered", so the first windowed request always misses.
// Assumes: load is pulsed once per completed select write.
module regwin_cache #(
    parameter int WIN_BITS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [WIN_BITS-1:0] load_win,
    input  logic [WIN_BITS-1:0] query_win,
    output logic                miss
);
    logic                cur_valid;
    logic [WIN_BITS-1:0] cur_win;

    // Capture the window number when a select write completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_valid <= 1'b0;
            cur_win   <= '0;
        end else if (load) begin
            cur_valid <= 1'b1;
            cur_win   <= load_win;
        end
    end

    // Miss when nothing is remembered or the window differs
    always_comb miss = !cur_valid || (cur_win != query_win);

    AST_CACHE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_valid && (cur_win == $past(load_win))) else $error("cache load"); // R9
    AST_CACHE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cur_valid) && $stable(cur_win)) else $error("cache hold"); // R9

endmodule

// File: rtl/regwin_seq.sv
// Transaction sequencer: captures one master request, issues the optional
// window-select write and then the data access on the slave port, and
// returns read data. The master port stays busy for the whole sequence.
// Assumes: the slave completes a request on s_valid && s_ready and answers
// each read with one s_rvalid pulse after its handshake.
module regwin_seq
    import regwin_pkg::*;
#(
    parameter int              ADDR_W       = 32,
    parameter int              DATA_W       = 32,
    parameter int              WIN_BITS     = 6,
    parameter logic [ADDR_W-1:0] SEL_OFFSET = ADDR_W'('h310C),
    parameter int              SEL_FLAG_BIT = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                m_valid,
    output logic                m_ready,
    input  logic                m_write,
    input  logic [ADDR_W-1:0]   m_addr,
    input  logic [DATA_W-1:0]   m_wdata,
    output logic                m_rvalid,
    output logic [DATA_W-1:0]   m_rdata,
    input  logic                use_window,
    input  logic [WIN_BITS-1:0] win_num,
    input  logic [ADDR_W-1:0]   ap_addr,
    input  logic                win_miss,
    output logic                cache_load,
    output logic [WIN_BITS-1:0] cache_load_win,
    output logic                s_valid,
    input  logic                s_ready,
    output logic                s_write,
    output logic [ADDR_W-1:0]   s_addr,
    output logic [DATA_W-1:0]   s_wdata,
    input  logic                s_rvalid,
    input  logic [DATA_W-1:0]   s_rdata
);
    seq_state_t          state, state_nx;
    logic                q_write;
    logic [ADDR_W-1:0]   q_addr;
    logic [DATA_W-1:0]   q_wdata;
    logic [WIN_BITS-1:0] q_win;
    logic [DATA_W-1:0]   sel_word;
    logic                rvalid_q;
    logic [DATA_W-1:0]   rdata_q;

    // Select register value: enable flag plus window number
    always_comb begin
        sel_word               = '0;
        sel_word[SEL_FLAG_BIT] = 1'b1;
        sel_word[WIN_BITS-1:0] = q_win;
    end

    // Next state and slave-side drive
    always_comb begin
        state_nx   = state;
        m_ready    = (state == ST_IDLE);
        s_valid    = 1'b0;
        s_write    = 1'b0;
        s_addr     = '0;
        s_wdata    = '0;
        cache_load = 1'b0;
        case (state)
            ST_IDLE: begin
                if (m_valid) begin
                    state_nx = (use_window && win_miss) ? ST_SEL : ST_ACC;
                end
            end
            ST_SEL: begin
                s_valid = 1'b1;
                s_write = 1'b1;
                s_addr  = SEL_OFFSET;
                s_wdata = sel_word;
                if (s_ready) begin
                    cache_load = 1'b1;
                    state_nx   = ST_ACC;
                end
            end
            ST_ACC: begin
                s_valid = 1'b1;
                s_write = q_write;
                s_addr  = q_addr;
                s_wdata = q_wdata;
                if (s_ready) begin
                    state_nx = q_write ? ST_IDLE : ST_RWAIT;
                end
            end
            ST_RWAIT: begin
                if (s_rvalid) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb cache_load_win = q_win;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Capture the request and its resolved target at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_addr  <= '0;
            q_wdata <= '0;
            q_win   <= '0;
        end else if (state == ST_IDLE && m_valid) begin
            q_write <= m_write;
            q_addr  <= use_window ? ap_addr : m_addr;
            q_wdata <= m_wdata;
            q_win   <= win_num;
        end
    end

    // One-cycle read response carrying the slave data unchanged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= (state == ST_RWAIT) && s_rvalid;
            if ((state == ST_RWAIT) && s_rvalid) begin
                rdata_q <= s_rdata;
            end
        end
    end

    always_comb begin
        m_rvalid = rvalid_q;
        m_rdata  = rdata_q;
    end

    AST_SLAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid && !s_ready |=> s_valid && $stable(s_addr) && $stable(s_write) && $stable(s_wdata))
        else $error("slave hold"); // R7
    AST_MASTER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |-> !m_ready) else $error("master locked"); // R6
    AST_SEL_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEL) && s_ready |=> s_valid && (state == ST_ACC) && !m_ready)
        else $error("select then data"); // R6
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        m_rvalid |=> !m_rvalid) else $error("rvalid pulse"); // R8
    AST_RDATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        m_rvalid |-> $past(s_rvalid) && (m_rdata == $past(s_rdata)) && m_ready)
        else $error("rdata pass"); // R8

endmodule

// File: rtl/regwin_bridge.sv
// Windowed register access bridge top. Low offsets and bypass-mode traffic
// pass through. Higher offsets are reached by a select write (only when the
// window changes) followed by an access into the fixed aperture.
// Assumes: single requests, no bursts; the slave never drops s_rvalid data.
module regwin_bridge #(
    parameter int                ADDR_W       = 32,
    parameter int                DATA_W       = 32,
    parameter int                WIN_SHIFT    = 19,
    parameter int                WIN_BITS     = 6,
    parameter logic [ADDR_W-1:0] SEL_OFFSET   = ADDR_W'('h310C),
    parameter int                SEL_FLAG_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              window_on,
    input  logic              m_valid,
    output logic              m_ready,
    input  logic              m_write,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              m_rvalid,
    output logic [DATA_W-1:0] m_rdata,
    output logic              s_valid,
    input  logic              s_ready,
    output logic              s_write,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_wdata,
    input  logic              s_rvalid,
    input  logic [DATA_W-1:0] s_rdata
);
    localparam logic [ADDR_W-1:0] APERTURE = ADDR_W'(1) << WIN_SHIFT;

    logic                use_window;
    logic [WIN_BITS-1:0] win_num;
    logic [ADDR_W-1:0]   ap_addr;
    logic                win_miss;
    logic                cache_load;
    logic [WIN_BITS-1:0] cache_load_win;

    regwin_decode #(
        .ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT), .WIN_BITS(WIN_BITS)
    ) u_decode (
        .window_on (window_on),
        .addr      (m_addr),
        .use_window(use_window),
        .win_num   (win_num),
        .ap_addr   (ap_addr)
    );

    regwin_cache #(
        .WIN_BITS(WIN_BITS)
    ) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cache_load),
        .load_win (cache_load_win),
        .query_win(win_num),
        .miss     (win_miss)
    );

    regwin_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS),
        .SEL_OFFSET(SEL_OFFSET), .SEL_FLAG_BIT(SEL_FLAG_BIT)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .m_valid       (m_valid),
        .m_ready       (m_ready),
        .m_write       (m_write),
        .m_addr        (m_addr),
        .m_wdata       (m_wdata),
        .m_rvalid      (m_rvalid),
        .m_rdata       (m_rdata),
        .use_window    (use_window),
        .win_num       (win_num),
        .ap_addr       (ap_addr),
        .win_miss      (win_miss),
        .cache_load    (cache_load),
        .cache_load_win(cache_load_win),
        .s_valid       (s_valid),
        .s_ready       (s_ready),
        .s_write       (s_write),
        .s_addr        (s_addr),
        .s_wdata       (s_wdata),
        .s_rvalid      (s_rvalid),
        .s_rdata       (s_rdata)
    );

    AST_LOW_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_ready && window_on && (m_addr < APERTURE)
        |=> s_valid && (s_addr == $past(m_addr)) && (s_write == $past(m_write)))
        else $error("low offset direct"); // R1
    AST_BYPASS_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_ready && !window_on
        |=> s_valid && (s_addr == $past(m_addr)) && (s_write == $past(m_write)))
        else $error("bypass direct"); // R2

endmodule

// File: tb/regwin_bridge_test.sv
`timescale 1ns/1ps
module regwin_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        window_on = 1'b1;
    logic        m_valid = 1'b0;
    logic        m_ready;
    logic        m_write = 1'b0;
    logic [31:0] m_addr = '0;
    logic [31:0] m_wdata = '0;
    logic        m_rvalid;
    logic [31:0] m_rdata;
    logic        s_valid;
    logic        s_ready;
    logic        s_write;
    logic [31:0] s_addr;
    logic [31:0] s_wdata;
    logic        s_rvalid;
    logic [31:0] s_rdata;

    always #5 clk = ~clk;

    regwin_bridge uut (
        .clk(clk), .rst_n(rst_n), .window_on(window_on),
        .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
        .s_valid(s_valid), .s_ready(s_ready), .s_write(s_write),
        .s_addr(s_addr), .s_wdata(s_wdata), .s_rvalid(s_rvalid), .s_rdata(s_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Slave read pattern, a pure function of the offset
    function automatic logic [31:0] rd_value(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    // Slave model log
    logic [31:0] log_addr [16];
    logic        log_wr   [16];
    logic [31:0] log_data [16];
    int          log_n = 0;

    // Slave model: random stalls, random read latency, stability check (R7)
    initial begin
        int          wait_cnt;
        int          rd_cnt;
        bit          rd_pend;
        bit          stalled;
        logic [31:0] rd_addr;
        logic [31:0] prev_addr;
        logic [31:0] prev_data;
        logic        prev_wr;
        s_ready  = 1'b0;
        s_rvalid = 1'b0;
        s_rdata  = '0;
        wait_cnt = 0;
        rd_cnt   = 0;
        rd_pend  = 1'b0;
        stalled  = 1'b0;
        rd_addr  = '0;
        prev_addr = '0;
        prev_data = '0;
        prev_wr   = 1'b0;
        forever begin
            @(negedge clk);
            s_rvalid = 1'b0;
            if (rd_pend) begin
                if (rd_cnt == 0) begin
                    s_rvalid = 1'b1;
                    s_rdata  = rd_value(rd_addr);
                    rd_pend  = 1'b0;
                end else begin
                    rd_cnt--;
                end
            end
            if (stalled) begin
                chk(s_valid && s_addr == prev_addr && s_wdata == prev_data && s_write == prev_wr,
                    "R7", "slave request held while stalled", s_addr, prev_addr);
            end
            if (rst_n && s_valid) begin
                if (wait_cnt == 0) begin
                    s_ready = 1'b1;
                    if (log_n < 16) begin
                        log_addr[log_n] = s_addr;
                        log_wr[log_n]   = s_write;
                        log_data[log_n] = s_wdata;
                    end
                    log_n++;
                    if (!s_write) begin
                        rd_pend = 1'b1;
                        rd_addr = s_addr;
                        rd_cnt  = int'($urandom % 2);
                    end
                    wait_cnt = int'($urandom % 3);
                    stalled  = 1'b0;
                end else begin
                    s_ready   = 1'b0;
                    wait_cnt--;
                    stalled   = 1'b1;
                    prev_addr = s_addr;
                    prev_data = s_wdata;
                    prev_wr   = s_write;
                end
            end else begin
                s_ready = 1'b0;
                stalled = 1'b0;
            end
        end
    end

    // Bench model of the remembered window
    bit         mdl_valid = 1'b0;
    logic [5:0] mdl_win   = '0;

    // One master request plus checks against the expected slave sequence
    task automatic do_txn(input bit en, input bit wr, input logic [31:0] addr,
                          input logic [31:0] data, input string cnt_tag);
        logic [31:0] e_addr [2];
        logic        e_wr   [2];
        logic [31:0] e_data [2];
        string       e_tag  [2];
        int          e_n;
        logic [5:0]  w;
        bit          early_rv;
        e_n = 0;
        w   = addr[24:19];
        if (!en || addr < 32'h0008_0000) begin
            e_addr[0] = addr; e_wr[0] = wr; e_data[0] = data;
            e_tag[0]  = en ? "R1" : "R2";
            e_n = 1;
        end else begin
            if (!mdl_valid || mdl_win != w) begin
                e_addr[e_n] = 32'h0000_310C; e_wr[e_n] = 1'b1;
                e_data[e_n] = 32'h8000_0000 | {26'd0, w};
                e_tag[e_n]  = mdl_valid ? "R4" : "R5";
                e_n++;
                mdl_valid = 1'b1;
                mdl_win   = w;
            end
            e_addr[e_n] = 32'h0008_0000 + (addr & 32'h0007_FFFF);
            e_wr[e_n] = wr; e_data[e_n] = data; e_tag[e_n] = "R3";
            e_n++;
        end
        @(negedge clk);
        chk(m_ready, "R6", "idle before request", {31'd0, m_ready}, 32'd1);
        log_n     = 0;
        window_on = en;
        m_valid   = 1'b1;
        m_write   = wr;
        m_addr    = addr;
        m_wdata   = data;
        @(negedge clk);
        m_valid  = 1'b0;
        early_rv = 1'b0;
        while (!m_ready) begin
            if (m_rvalid) early_rv = 1'b1;
            @(negedge clk);
        end
        chk(log_n == e_n, cnt_tag, "slave transaction count", 32'(log_n), 32'(e_n));
        for (int i = 0; i < e_n && i < log_n; i++) begin
            chk(log_addr[i] == e_addr[i], e_tag[i], "slave offset", log_addr[i], e_addr[i]);
            chk(log_wr[i] == e_wr[i], e_tag[i], "slave direction", {31'd0, log_wr[i]}, {31'd0, e_wr[i]});
            if (e_wr[i]) begin
                chk(log_data[i] == e_data[i], e_tag[i], "slave write data", log_data[i], e_data[i]);
            end
        end
        chk(!early_rv, "R8", "no read valid before completion", {31'd0, early_rv}, 32'd0);
        if (!wr) begin
            chk(m_rvalid, "R8", "read valid at completion", {31'd0, m_rvalid}, 32'd1);
            chk(m_rdata == rd_value(e_addr[e_n-1]), "R8", "read data", m_rdata, rd_value(e_addr[e_n-1]));
        end else begin
            chk(!m_rvalid, "R8", "no read valid on write", {31'd0, m_rvalid}, 32'd0);
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog: actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(m_ready == 1'b1, "R10", "m_ready in reset", {31'd0, m_ready}, 32'd1);
        chk(s_valid == 1'b0, "R10", "s_valid in reset", {31'd0, s_valid}, 32'd0);
        chk(m_rvalid == 1'b0, "R10", "m_rvalid in reset", {31'd0, m_rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(m_ready == 1'b1 && s_valid == 1'b0, "R10", "idle after reset",
            {30'd0, m_ready, s_valid}, 32'd2);

        do_txn(1'b1, 1'b0, 32'h0000_1234, 32'h0, "R1");          // low read
        do_txn(1'b1, 1'b1, 32'h0007_FFFC, 32'hDEAD_0001, "R1");  // just below aperture
        do_txn(1'b1, 1'b0, 32'h0200_0010, 32'h0, "R5");          // first windowed, window 0
        do_txn(1'b1, 1'b1, 32'h0008_0000, 32'hCAFE_0002, "R3");  // aperture base, window 1
        do_txn(1'b1, 1'b0, 32'h0008_0040, 32'h0, "R4");          // same window, no select
        do_txn(1'b0, 1'b1, 32'h0150_0000, 32'h1111_2222, "R2");  // bypass, other window
        do_txn(1'b1, 1'b0, 32'h000F_FFFC, 32'h0, "R9");          // window 1 still remembered
        do_txn(1'b1, 1'b1, 32'h01FF_FFFC, 32'h3333_4444, "R3");  // top window 63

        for (int k = 0; k < 400; k++) begin
            logic [31:0] a;
            bit          en;
            bit          wr;
            en = ($urandom % 5) != 0;
            wr = $urandom % 2;
            case ($urandom % 4)
                0:       a = {13'd0, 17'($urandom), 2'b00};
                1:       a = {7'd0, 6'd5, 17'($urandom), 2'b00};
                2:       a = {7'd0, 6'd9, 17'($urandom), 2'b00};
                default: a = {7'($urandom), 6'($urandom % 8), 17'($urandom), 2'b00};
            endcase
            do_txn(en, wr, a, $urandom, en ? "R3" : "R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule